// File: doc/BRIEF.md
# Unaligned Word Load Merger

This unit sits between a processor load port and a data cache that serves only naturally aligned 32-bit words. The processor hands it a byte address and a load strobe. The unit returns the 32-bit value that starts at that byte, whatever the alignment of that byte.

When the low two address bits are zero, the value lies in one aligned word and the unit makes one cache read. Otherwise the value spans two neighbouring aligned words, which may sit in different cache lines. The unit then reads the lower word, keeps it in a holding register, and reads the next word. It builds the result with little-endian byte order, using the low two bits of the address. Every read waits for the cache's valid response, so a miss on either read shows up only as a longer wait. A one-cycle done pulse marks the result. The unit takes a new load only when it is idle.

Top module: `unaligned_load_merger`

## Requirements
- R1: During and directly after reset, busy_o, done_o and cache_req_o are all low.
- R2: A load strobe is taken only while the unit is idle. A strobe raised while busy_o is high starts no extra cache read and does not change the result of the load in progress.
- R3: busy_o rises in the cycle after the strobe is taken. It stays high through the done cycle and is low in the cycle after done_o.
- R4: cache_addr_o carries only the word address, ld_addr_i[31:2], for the first read. The two byte-select bits never reach the cache.
- R5: When ld_addr_i[1:0] is 2'b00, exactly one cache read is made.
- R6: When ld_addr_i[1:0] is not 2'b00, exactly two cache reads are made. The second read goes to the first word address plus one.
- R7: The second word address wraps modulo 2^30, so the word after 30'h3FFFFFFF is word 0.
- R8: Let k = ld_addr_i[1:0], W0 be the first word and W1 be the second word. The result is bytes k..3 of W0 in the low positions, followed by bytes 0..k-1 of W1, which is ({W1,W0} >> 8k)[31:0].
- R9: While cache_req_o is high and cache_valid_i is low, cache_req_o stays high and cache_addr_o stays stable. A read completes only in a cycle in which cache_req_o and cache_valid_i are both high. The response latency may be any number of cycles.
- R10: done_o is high for exactly one cycle. ld_data_o holds the result in that cycle and keeps it until the next load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_req_i | input | 1 | Load strobe |
| ld_addr_i | input | 32 | Byte address of the load |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse: ld_data_o is valid |
| ld_data_o | output | 32 | Merged load result |
| cache_req_o | output | 1 | Cache read request |
| cache_addr_o | output | 30 | Aligned word address sent to the cache |
| cache_valid_i | input | 1 | Cache response valid |
| cache_rdata_i | input | 32 | Aligned word returned by the cache |

## Verification
Two events can fall in the same cycle. A new load strobe can arrive in the same cycle that the cache returns the first word, and a cache response can arrive in the very first cycle of a read. The bench raises a stray strobe with a different address in the cycle after a load is taken. It also lets the cache model answer with zero extra latency, and with up to a dozen cycles of delay for each read. It then checks that only the reads of the accepted load appear, with the expected word addresses, and that the merged value matches the little-endian formula worked out in the bench.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_LO  = 2'd1,
    ST_RD_HI  = 2'd2,
    ST_DONE   = 2'd3
  } ldm_state_e;
endpackage

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
  import ldm_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_req_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             cache_valid_i,
  output logic             accept_o,
  output logic             sel_hi_o,
  output logic             cap_lo_o,
  output logic             cap_res_o,
  output logic             use_hold_o,
  output logic             cache_req_o,
  output logic             busy_o,
  output logic             done_o
);
  ldm_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    cap_lo_o   = 1'b0;
    cap_res_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ld_req_i) begin
        accept_o = 1'b1;
        state_d  = ST_RD_LO;
      end
      ST_RD_LO: if (cache_valid_i) begin
        if (off_i == '0) begin
          cap_res_o = 1'b1;
          state_d   = ST_DONE;
        end else begin
          cap_lo_o = 1'b1;
          state_d  = ST_RD_HI;
        end
      end
      ST_RD_HI: if (cache_valid_i) begin
        cap_res_o = 1'b1;
        state_d   = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign sel_hi_o    = (state_q == ST_RD_HI);
  assign use_hold_o  = (state_q == ST_RD_HI);
  assign cache_req_o = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ld_req_i) |=> busy_o);
  // R3
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R5
  aligned_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_hi_o |-> off_i != '0);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_o && !cache_valid_i) |=> cache_req_o);
endmodule

// File: rtl/ldm_addr.sv
module ldm_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic               sel_hi_i,
  input  logic               cache_req_i,
  input  logic               cache_valid_i,
  output logic [OFF_W-1:0]   off_o,
  output logic [WADDR_W-1:0] word_addr_o
);
  logic [WADDR_W-1:0] base_q;
  logic [OFF_W-1:0]   off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (accept_i) begin
      base_q <= ld_addr_i[ADDR_W-1:OFF_W];
      off_q  <= ld_addr_i[OFF_W-1:0];
    end
  end

  // next word wraps naturally at the top of the word space
  assign word_addr_o = sel_hi_i ? base_q + WADDR_W'(1) : base_q;
  assign off_o       = off_q;

  // R6
  hi_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_hi_i) |-> word_addr_o == $past(word_addr_o) + WADDR_W'(1));
  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_i && !cache_valid_i) |=> $stable(word_addr_o));
endmodule

// File: rtl/ldm_merge.sv
module ldm_merge #(
  parameter int BYTES = 4,
  localparam int DATA_W = 8 * BYTES,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              cap_lo_i,
  input  logic              cap_res_i,
  input  logic              use_hold_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0]   hold_q, res_q, lo_w, merged;
  logic [2*DATA_W-1:0] cat;

  assign lo_w = use_hold_i ? hold_q : rdata_i;
  assign cat  = {rdata_i, lo_w};

  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    logic [OFF_W:0] idx;
    assign idx = (OFF_W+1)'(j) + {1'b0, off_i};
    assign merged[8*j +: 8] = cat[8*idx +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      res_q  <= '0;
    end else begin
      if (cap_lo_i)  hold_q <= rdata_i;
      if (cap_res_i) res_q  <= merged;
    end
  end

  assign result_o = res_q;

  // R10
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cap_res_i) |-> $stable(res_q));
endmodule

// File: rtl/unaligned_load_merger.sv
module unaligned_load_merger #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int DATA_W  = 8 * BYTES,
  localparam int OFF_W   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_req_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  ld_data_o,
  output logic               cache_req_o,
  output logic [WADDR_W-1:0] cache_addr_o,
  input  logic               cache_valid_i,
  input  logic [DATA_W-1:0]  cache_rdata_i
);
  logic accept, sel_hi, cap_lo, cap_res, use_hold;
  logic [OFF_W-1:0] off;

  ldm_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni, .ld_req_i, .off_i(off), .cache_valid_i,
    .accept_o(accept), .sel_hi_o(sel_hi), .cap_lo_o(cap_lo),
    .cap_res_o(cap_res), .use_hold_o(use_hold), .cache_req_o,
    .busy_o, .done_o
  );

  ldm_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk_i, .rst_ni, .accept_i(accept), .ld_addr_i, .sel_hi_i(sel_hi),
    .cache_req_i(cache_req_o), .cache_valid_i,
    .off_o(off), .word_addr_o(cache_addr_o)
  );

  ldm_merge #(.BYTES(BYTES)) u_merge (
    .clk_i, .rst_ni, .off_i(off), .rdata_i(cache_rdata_i),
    .cap_lo_i(cap_lo), .cap_res_i(cap_res), .use_hold_i(use_hold),
    .result_o(ld_data_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !done_o && !cache_req_o);
  // R2
  req_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_req_o |-> busy_o);
endmodule

// File: tb/unaligned_load_merger_tb_top.sv
`timescale 1ns/1ps
module unaligned_load_merger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0;
  logic [31:0] ld_addr = '0;
  logic        busy, done, cache_req, cache_valid = 1'b0;
  logic [31:0] ld_data, cache_rdata = '0;
  logic [29:0] cache_addr;

  int checks = 0, fails = 0;
  int rd_cnt = 0;
  logic [29:0] rd_addr [4];
  int wait_cnt = 0;
  int max_lat = 3;

  always #2.5 clk = ~clk;

  unaligned_load_merger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ld_req_i(ld_req), .ld_addr_i(ld_addr),
    .busy_o(busy), .done_o(done), .ld_data_o(ld_data),
    .cache_req_o(cache_req), .cache_addr_o(cache_addr),
    .cache_valid_i(cache_valid), .cache_rdata_i(cache_rdata)
  );

  function automatic logic [31:0] mem_w(logic [29:0] wa);
    return ({2'b00, wa} * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  function automatic logic [31:0] exp_val(logic [31:0] a);
    logic [63:0] cat;
    cat = {mem_w(a[31:2] + 30'd1), mem_w(a[31:2])};
    return 32'(cat >> (8 * a[1:0]));
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cache model: answers each request after a random number of cycles
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      cache_valid = 1'b0;
      wait_cnt = 0;
    end else if (cache_valid) begin
      cache_valid = 1'b0;
      wait_cnt = $urandom % (max_lat + 1);
    end else if (cache_req) begin
      if (wait_cnt == 0) begin
        cache_valid = 1'b1;
        cache_rdata = mem_w(cache_addr);
        if (rd_cnt < 4) rd_addr[rd_cnt] = cache_addr;
        rd_cnt++;
      end else wait_cnt--;
    end
  end

  task automatic do_load(logic [31:0] a, bit stray);
    logic [31:0] exp_d;
    int n;
    bit seen;
    exp_d = exp_val(a);
    rd_cnt = 0;
    @(negedge clk);
    ld_req = 1'b1;
    ld_addr = a;
    @(negedge clk);
    // R3 busy after acceptance
    chk(busy == 1'b1, "R3 busy after accept", 64'(busy), 64'd1);
    if (stray) begin
      ld_req = 1'b1;
      ld_addr = a ^ 32'h0000_1235;
    end else ld_req = 1'b0;
    seen = 1'b0;
    n = 0;
    while (!seen && n < 200) begin
      if (done) seen = 1'b1;
      else begin
        @(negedge clk);
        ld_req = 1'b0;
        n++;
      end
    end
    chk(seen, "R10 done seen", 64'(seen), 64'd1);
    // R8 merged value, R2 stray request has no effect
    chk(ld_data == exp_d, stray ? "R2 R8 data" : "R8 data", 64'(ld_data), 64'(exp_d));
    chk(busy == 1'b1, "R3 busy in done", 64'(busy), 64'd1);
    if (a[1:0] == 2'b00)
      chk(rd_cnt == 1, "R5 one read", 64'(rd_cnt), 64'd1);
    else
      chk(rd_cnt == 2, stray ? "R2 R6 two reads" : "R6 two reads", 64'(rd_cnt), 64'd2);
    // R4 first address is the word part
    chk(rd_addr[0] == a[31:2], "R4 first addr", 64'(rd_addr[0]), 64'(a[31:2]));
    if (a[1:0] != 2'b00)
      // R6 R7 second address with wrap
      chk(rd_addr[1] == a[31:2] + 30'd1, "R6 R7 second addr",
          64'(rd_addr[1]), 64'(a[31:2] + 30'd1));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 R3 pulse end", {62'd0, done, busy}, 64'd0);
    chk(ld_data == exp_d, "R10 data held", 64'(ld_data), 64'(exp_d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !cache_req, "R1 reset", {61'd0, busy, done, cache_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cache_req, "R1 after reset", {61'd0, busy, done, cache_req}, 64'd0);
    for (int k = 0; k < 4; k++) do_load(32'h0000_1000 + k, 1'b0);
    do_load(32'hFFFF_FFFF, 1'b0);   // R7 wrap
    do_load(32'hFFFF_FFFD, 1'b0);   // R7
    do_load(32'hFFFF_FFFC, 1'b0);   // R5 top aligned
    do_load(32'h0000_0003, 1'b1);   // R2 stray strobe
    do_load(32'h0000_0040, 1'b1);   // R2 aligned stray strobe
    max_lat = 0;                    // R9 immediate responses
    for (int k = 0; k < 4; k++) do_load(32'h0000_7FF0 + k, k[0]);
    max_lat = 12;                   // R9 long miss latency
    for (int k = 0; k < 4; k++) do_load(32'h8000_0000 + k, 1'b0);
    max_lat = 5;
    for (int i = 0; i < 200; i++) do_load($urandom, ($urandom % 4) == 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule